// File: doc/BRIEF.md
# Dual-Generator Uniform Random Word Source

This block produces a stream of 32-bit pseudo-random words, one per enabled clock, that a stochastic sampler treats as a uniform fraction in [0, 1). The sampler multiplies this fraction by its final cumulative probability sum to get the threshold that picks a label. Two generators of different structure run in lockstep, and their low bits are mixed into each output word. The first is a 43-bit Fibonacci linear feedback shift register. The second is a 37-bit one-dimensional cellular automaton with zero boundaries and a mix of rule 90 and rule 150 cells.

The host loads the state of both generators with a single strobe. A seed of all zeros is replaced by a fixed nonzero pattern, so the block can always run. Steps happen only while the enable input is high. Each step updates both registers and the registered output word, and a valid pulse marks the cycle in which the new word appears.

Top module: `hybrid_urng`

## Requirements
- R1: Synchronous active-high reset clears `rnd` to 0 and `rnd_vld` to 0, and sets the linear register to 43'h5A5C3C31E1E and the automaton to 37'h123456789.
- R2: On each step the linear register s[42:0] becomes {s[41:0], s[42]^s[40]^s[19]^s[0]}, which is the maximal-length polynomial x^43+x^41+x^20+x+1.
- R3: On each step every automaton cell i becomes c[i-1]^c[i+1]. Cells past either end read as 0. Cell 28 also XORs in its own value, c[28].
- R4: A step happens on a clock edge where `en`=1 and `seed_we`=0. After that edge, `rnd` equals the low 32 bits of the new linear state XOR the low 32 bits of the new automaton state, and `rnd_vld` is 1.
- R5: On an edge where `en`=0 and `seed_we`=0, both states hold, `rnd` holds, and `rnd_vld` is 0 after the edge.
- R6: On an edge where `seed_we`=1, the linear register takes `seed_lfsr` and the automaton takes `seed_ca`. After that edge `rnd_vld` is 0 and `rnd` holds.
- R7: A seed of all zeros is replaced by that register's reset constant from R1, and each register is checked for zero on its own.
- R8: When `seed_we` and `en` are both 1 on the same edge, the load takes priority and no step happens.
- R9: Neither register ever holds the all-zero state outside reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_we | input | 1 | Load strobe for both generator states |
| seed_lfsr | input | 43 | Seed for the linear register |
| seed_ca | input | 37 | Seed for the automaton register |
| en | input | 1 | Advance both generators by one step |
| rnd | output | 32 | Registered uniform random word |
| rnd_vld | output | 1 | High for one cycle after each step |

## Verification
A seed load and a step request can arrive on the same edge. The bench forces this with directed cycles where both strobes are high, and its random phase also raises both strobes together at times. It judges the result by the missing valid pulse and the unchanged word. It also checks that the next enabled step continues from the loaded seed and not from a state that was advanced once. Zero seeds, applied to one register at a time and to both, confirm that each substitution happens on its own.

// File: rtl/hybrid_urng_pkg.sv
package hybrid_urng_pkg;
  localparam int LFSR_W = 43;
  localparam int CA_W   = 37;
  localparam int OUT_W  = 32;
  // feedback taps: bits 42, 40, 19, 0
  localparam logic [LFSR_W-1:0] LFSR_TAPS  = 43'h50000080001;
  localparam logic [LFSR_W-1:0] LFSR_INIT  = 43'h5A5C3C31E1E;
  // rule-150 cells (self term included): cell 28
  localparam logic [CA_W-1:0]   CA_SELF    = 37'h0010000000;
  localparam logic [CA_W-1:0]   CA_INIT    = 37'h123456789;
endpackage

// File: rtl/hybrid_urng_lfsr.sv
module hybrid_urng_lfsr
  import hybrid_urng_pkg::*;
#(
  parameter int                W     = LFSR_W,
  parameter int                OW    = OUT_W,
  parameter logic [W-1:0]      TAPS  = LFSR_TAPS,
  parameter logic [W-1:0]      INIT  = LFSR_INIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  seed,
  input  logic          step,
  output logic [W-1:0]  state_q,
  output logic [OW-1:0] nxt_lo
);
  logic [W-1:0] nxt;
  logic         fb;

  always_comb begin
    fb     = ^(state_q & TAPS);
    nxt    = {state_q[W-2:0], fb};
    nxt_lo = nxt[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      state_q <= INIT;
    else if (load)
      state_q <= (seed == '0) ? INIT : seed;
    else if (step)
      state_q <= nxt;
  end
endmodule

// File: rtl/hybrid_urng_ca.sv
module hybrid_urng_ca
  import hybrid_urng_pkg::*;
#(
  parameter int                W     = CA_W,
  parameter int                OW    = OUT_W,
  parameter logic [W-1:0]      SELF  = CA_SELF,
  parameter logic [W-1:0]      INIT  = CA_INIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  seed,
  input  logic          step,
  output logic [W-1:0]  state_q,
  output logic [OW-1:0] nxt_lo
);
  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_cell
    logic lft, rgt, own;
    if (i == 0) begin : g_lo
      assign lft = 1'b0;
    end else begin : g_lo
      assign lft = state_q[i-1];
    end
    if (i == W-1) begin : g_hi
      assign rgt = 1'b0;
    end else begin : g_hi
      assign rgt = state_q[i+1];
    end
    if (SELF[i]) begin : g_r150
      assign own = state_q[i];
    end else begin : g_r90
      assign own = 1'b0;
    end
    assign nxt[i] = lft ^ rgt ^ own;
  end

  assign nxt_lo = nxt[OW-1:0];

  always_ff @(posedge clk) begin
    if (rst)
      state_q <= INIT;
    else if (load)
      state_q <= (seed == '0) ? INIT : seed;
    else if (step)
      state_q <= nxt;
  end
endmodule

// File: rtl/hybrid_urng_mix.sv
module hybrid_urng_mix
  import hybrid_urng_pkg::*;
#(
  parameter int OW = OUT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [OW-1:0] a_lo,
  input  logic [OW-1:0] b_lo,
  output logic [OW-1:0] word_q,
  output logic          vld_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= fire;
      if (fire)
        word_q <= a_lo ^ b_lo;
    end
  end
endmodule

// File: rtl/hybrid_urng.sv
module hybrid_urng
  import hybrid_urng_pkg::*;
#(
  parameter int LW = LFSR_W,
  parameter int CW = CA_W,
  parameter int OW = OUT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          seed_we,
  input  logic [LW-1:0] seed_lfsr,
  input  logic [CW-1:0] seed_ca,
  input  logic          en,
  output logic [OW-1:0] rnd,
  output logic          rnd_vld
);
  logic [LW-1:0] lfsr_q;
  logic [CW-1:0] ca_q;
  logic [OW-1:0] lfsr_lo, ca_lo;
  logic          fire;

  // load wins over step
  assign fire = en & ~seed_we;

  hybrid_urng_lfsr #(.W(LW), .OW(OW)) u_lfsr (
    .clk(clk), .rst(rst), .load(seed_we), .seed(seed_lfsr),
    .step(fire), .state_q(lfsr_q), .nxt_lo(lfsr_lo)
  );

  hybrid_urng_ca #(.W(CW), .OW(OW)) u_ca (
    .clk(clk), .rst(rst), .load(seed_we), .seed(seed_ca),
    .step(fire), .state_q(ca_q), .nxt_lo(ca_lo)
  );

  hybrid_urng_mix #(.OW(OW)) u_mix (
    .clk(clk), .rst(rst), .fire(fire), .a_lo(lfsr_lo), .b_lo(ca_lo),
    .word_q(rnd), .vld_q(rnd_vld)
  );
endmodule

// File: rtl/hybrid_urng_chk.sv
module hybrid_urng_chk #(
  parameter int LW = 43,
  parameter int CW = 37,
  parameter int OW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          seed_we,
  input logic [LW-1:0] seed_lfsr,
  input logic [CW-1:0] seed_ca,
  input logic          en,
  input logic [OW-1:0] rnd,
  input logic          rnd_vld,
  input logic [LW-1:0] lfsr_q,
  input logic [CW-1:0] ca_q
);
  // R4
  vld_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rnd_vld |-> ($past(en) && !$past(seed_we)));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !seed_we) |=> ($stable(lfsr_q) && $stable(ca_q) && $stable(rnd) && !rnd_vld));
  // R6
  load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    seed_we |=> (!rnd_vld && $stable(rnd)));
  // R6
  load_lfsr_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_we && seed_lfsr != '0) |=> (lfsr_q == $past(seed_lfsr)));
  // R6
  load_ca_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_we && seed_ca != '0) |=> (ca_q == $past(seed_ca)));
  // R9
  nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (lfsr_q != '0) && (ca_q != '0));
endmodule

bind hybrid_urng hybrid_urng_chk #(.LW(LW), .CW(CW), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .seed_we(seed_we), .seed_lfsr(seed_lfsr),
  .seed_ca(seed_ca), .en(en), .rnd(rnd), .rnd_vld(rnd_vld),
  .lfsr_q(lfsr_q), .ca_q(ca_q)
);

// File: tb/sim_hybrid_urng.sv
`timescale 1ns/1ps
module sim_hybrid_urng;
  logic        clk = 1'b0;
  logic        rst;
  logic        seed_we;
  logic [42:0] seed_lfsr;
  logic [36:0] seed_ca;
  logic        en;
  logic [31:0] rnd;
  logic        rnd_vld;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [42:0] m_l;
  logic [36:0] m_c;
  logic [31:0] m_rnd;
  logic        m_vld;

  localparam logic [42:0] L_INIT = 43'h5A5C3C31E1E;
  localparam logic [36:0] C_INIT = 37'h123456789;

  always #4 clk = ~clk;

  hybrid_urng u0 (
    .clk(clk), .rst(rst), .seed_we(seed_we), .seed_lfsr(seed_lfsr),
    .seed_ca(seed_ca), .en(en), .rnd(rnd), .rnd_vld(rnd_vld)
  );

  function automatic logic [42:0] l_next(input logic [42:0] s);
    return {s[41:0], s[42] ^ s[40] ^ s[19] ^ s[0]};
  endfunction

  function automatic logic [36:0] c_next(input logic [36:0] s);
    logic [36:0] r;
    for (int i = 0; i < 37; i++) begin
      logic lf, rt;
      lf = (i == 0)  ? 1'b0 : s[i-1];
      rt = (i == 36) ? 1'b0 : s[i+1];
      r[i] = lf ^ rt ^ ((i == 28) ? s[i] : 1'b0);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] er, input logic ev);
    n_tests++;
    if (rnd !== er || rnd_vld !== ev) begin
      n_fail++;
      $display("FAIL %s: rnd=%h vld=%b expected rnd=%h vld=%b", req, rnd, rnd_vld, er, ev);
    end
  endtask

  // one edge with given inputs, model update, check at the following negedge
  task automatic cyc(input logic we, input logic [42:0] sl, input logic [36:0] sc,
                     input logic e, input string req);
    seed_we = we; seed_lfsr = sl; seed_ca = sc; en = e;
    @(posedge clk);
    if (we) begin
      m_l = (sl == '0) ? L_INIT : sl;
      m_c = (sc == '0) ? C_INIT : sc;
      m_vld = 1'b0;
    end else if (e) begin
      m_l = l_next(m_l);
      m_c = c_next(m_c);
      m_rnd = m_l[31:0] ^ m_c[31:0];
      m_vld = 1'b1;
    end else begin
      m_vld = 1'b0;
    end
    @(negedge clk);
    check(req, m_rnd, m_vld);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; seed_we = 0; seed_lfsr = '0; seed_ca = '0; en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_l = L_INIT; m_c = C_INIT; m_rnd = '0; m_vld = 0;
    check("R1 reset", 32'h0, 1'b0);

    // R1/R2/R3/R4: steps from reset constants
    for (int k = 0; k < 5; k++) cyc(0, '0, '0, 1, "R4 step from reset R1 R2 R3");
    // R5: idle holds
    cyc(0, '0, '0, 0, "R5 idle");
    cyc(0, '0, '0, 0, "R5 idle");
    cyc(0, '0, '0, 1, "R5 resume after idle");
    // R6: seed load, then steps
    cyc(1, 43'h00000000001, 37'h1000000000, 0, "R6 load");
    for (int k = 0; k < 4; k++) cyc(0, '0, '0, 1, "R2 R3 step from seed");
    // R7: zero seeds, one register at a time and both
    cyc(1, '0, 37'h0ABCDEF01, 0, "R7 zero lfsr seed");
    cyc(0, '0, '0, 1, "R7 step after zero lfsr seed");
    cyc(1, 43'h12345678901, '0, 0, "R7 zero ca seed");
    cyc(0, '0, '0, 1, "R7 step after zero ca seed");
    cyc(1, '0, '0, 0, "R7 both zero");
    cyc(0, '0, '0, 1, "R7 step after both zero");
    // R8: load and enable together
    cyc(1, 43'h7FFFFFFFFFF, 37'h1FFFFFFFFF, 1, "R8 load beats enable");
    cyc(0, '0, '0, 1, "R8 step continues from loaded seed");
    cyc(1, 43'h00000000ABC, 37'h0000000DEF, 1, "R8 load beats enable again");
    cyc(1, 43'h00000000ABC, 37'h0000000DEF, 1, "R8 back-to-back load");
    cyc(0, '0, '0, 1, "R8 step after loads");

    // random phase: R2 R3 R4 R5 R6 R7 R8 R9
    for (int k = 0; k < 3000; k++) begin
      logic        w, e;
      logic [42:0] sl;
      logic [36:0] sc;
      w  = ($urandom % 20) == 0;
      e  = ($urandom % 4) != 0;
      sl = {$urandom, $urandom} & 43'h7FFFFFFFFFF;
      sc = {$urandom, $urandom} & 37'h1FFFFFFFFF;
      if (($urandom % 4) == 0) sl = '0;
      if (($urandom % 4) == 0) sc = '0;
      cyc(w, sl, sc, e, "R9 random R2 R3 R4");
    end

    // reset mid-run returns to R1 state
    seed_we = 0; en = 1; rst = 1;
    @(posedge clk); @(negedge clk);
    rst = 0; en = 0;
    m_l = L_INIT; m_c = C_INIT; m_rnd = '0; m_vld = 0;
    check("R1 reset mid-run", 32'h0, 1'b0);
    cyc(0, '0, '0, 1, "R1 first step after reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule